// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives characters on the single shared data wire of an asynchronous half-duplex smart-card link. It watches the wire for a falling edge, checks that the line is still low half a bit later, and then samples eight data bits and a parity bit. Each bit is sampled at its middle, and one bit lasts a fixed number of base clock cycles. The first data bit received is the least significant, and a high level reads as 1.

When the character passes the even-parity check, its byte is loaded into the data register and the receive-full flag is set. When the check fails, the byte is thrown away and the parity-error flag is set. Half a bit after the parity sample point, the block then pulls the wire low through an open-drain output enable, which tells the card to send the character again. The retransmitted character is received in the same way as any new one. A read strobe from software or a DMA engine clears receive-full. A separate strobe clears the error flags. Level interrupt outputs follow the flags while interrupts are enabled.

Top module: `scard_rx`

## Requirements
- R1: After reset, data_o is 0, full_o, per_o and ovr_o are 0, and line_oe_o is 0.
- R2: A character starts only on a falling edge of line_i that is still low half a bit period later. A shorter low pulse is ignored: no flag changes and the line is not driven.
- R3: A character is a low start bit, then data bits 0 to 7 with the least significant first, then a parity bit. Each bit lasts BIT_CYC clock cycles and is sampled at its middle. A high level reads as 1.
- R4: When the nine received bits hold an even number of ones and full_o is 0, data_o takes the received byte and full_o is set.
- R5: When the nine received bits hold an odd number of ones, per_o is set, and full_o and data_o are left unchanged.
- R6: After a parity failure, line_oe_o is high for exactly ERR_CYC cycles, starting half a bit period after the parity sample (about ten bit periods after the start edge). line_oe_o stays 0 for a character with good parity.
- R7: A pulse on rd_i clears full_o.
- R8: A pulse on err_clr_i clears per_o and ovr_o. A character that arrives afterwards is received normally.
- R9: When a character with good parity completes while full_o is already 1, ovr_o is set and data_o keeps its old value.
- R10: rxi_o equals full_o AND rie_i. eri_o equals (per_o OR ovr_o) AND rie_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Level sensed on the shared data wire |
| line_oe_o | output | 1 | Pulls the wire low while high (open drain) |
| rie_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Data register read strobe, clears receive-full |
| err_clr_i | input | 1 | Clears the parity-error and overrun flags |
| data_o | output | 8 | Received byte |
| full_o | output | 1 | Receive-full flag |
| per_o | output | 1 | Parity-error flag |
| ovr_o | output | 1 | Overrun flag |
| rxi_o | output | 1 | Receive interrupt |
| eri_o | output | 1 | Error interrupt |

## Verification
The hardest case to reach from the ports is the error slot. There the receiver's own output enable must win over an idle-high card on the shared wire, and the pulse has to start and end at the right distance from a start edge that went through a synchronizer. The bench models the wire as an open-drain AND of the card and the receiver. It sends deliberately corrupted parity on many byte values and measures where the output-enable pulse starts and how long it lasts, relative to each character's start edge. Overrun is reached by sending a second good character without a read in between.

// File: rtl/scrx_pkg.sv
package scrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_SLOT,
    ST_ERR
  } scrx_state_e;

  localparam int unsigned FRAME_BITS = 9;  // 8 data + parity
endpackage

// File: rtl/scrx_sync.sv
module scrx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], line_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign line_s_o = sr_q[STAGES-1];
  assign fall_o   = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/scrx_timer.sv
module scrx_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= val_i - 1'b1;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign expire_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/scrx_frame.sv
module scrx_frame
  import scrx_pkg::*;
#(
  parameter int unsigned BIT_CYC = 372,
  parameter int unsigned ERR_CYC = 372
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_s_i,
  input  logic       fall_i,
  output logic       done_o,
  output logic       good_o,
  output logic [7:0] byte_o,
  output logic       oe_o
);
  localparam int unsigned MAXC = (BIT_CYC > ERR_CYC) ? BIT_CYC : ERR_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);
  localparam int unsigned HALF = BIT_CYC / 2;
  localparam int unsigned IW   = $clog2(FRAME_BITS);

  scrx_state_e        st_q, st_d;
  logic [8:0]         sh_q;
  logic [IW-1:0]      idx_q;
  logic               bad_q;
  logic               load;
  logic [TW-1:0]      val;
  logic               expire;
  logic [8:0]         word;

  scrx_timer #(.W(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .val_i    (val),
    .expire_o (expire)
  );

  assign word   = {line_s_i, sh_q[8:1]};
  assign done_o = (st_q == ST_BITS) && expire && (idx_q == IW'(FRAME_BITS - 1));
  assign byte_o = word[7:0];
  assign good_o = ~^word;
  assign oe_o   = (st_q == ST_ERR);

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    val  = TW'(BIT_CYC);
    unique case (st_q)
      ST_IDLE: if (fall_i) begin
        st_d = ST_START; load = 1'b1; val = TW'(HALF);
      end
      ST_START: if (expire) begin
        if (!line_s_i) begin st_d = ST_BITS; load = 1'b1; end
        else st_d = ST_IDLE;
      end
      ST_BITS: if (expire) begin
        load = 1'b1;
        if (done_o) begin st_d = ST_SLOT; val = TW'(BIT_CYC - HALF); end
      end
      ST_SLOT: if (expire) begin
        if (bad_q) begin st_d = ST_ERR; load = 1'b1; val = TW'(ERR_CYC); end
        else st_d = ST_IDLE;
      end
      ST_ERR: if (expire) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      idx_q <= '0;
      bad_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_START && expire) idx_q <= '0;
      if (st_q == ST_BITS && expire) begin
        sh_q  <= word;
        idx_q <= idx_q + 1'b1;
      end
      if (done_o) bad_q <= ~good_o;
    end
  end
endmodule

// File: rtl/scard_rx.sv
module scard_rx #(
  parameter int unsigned BIT_CYC     = 372,
  parameter int unsigned ERR_CYC     = 372,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       line_oe_o,
  input  logic       rie_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic       full_o,
  output logic       per_o,
  output logic       ovr_o,
  output logic       rxi_o,
  output logic       eri_o
);
  logic       line_s, fall;
  logic       frame_done, frame_good;
  logic [7:0] frame_byte;
  logic [7:0] data_q;
  logic       full_q, per_q, ovr_q;

  scrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  scrx_frame #(.BIT_CYC(BIT_CYC), .ERR_CYC(ERR_CYC)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_s_i (line_s),
    .fall_i   (fall),
    .done_o   (frame_done),
    .good_o   (frame_good),
    .byte_o   (frame_byte),
    .oe_o     (line_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      per_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_i)      full_q <= 1'b0;
      if (err_clr_i) begin per_q <= 1'b0; ovr_q <= 1'b0; end
      if (frame_done) begin
        if (!frame_good)  per_q <= 1'b1;
        else if (full_q && !rd_i) ovr_q <= 1'b1;
        else begin
          data_q <= frame_byte;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign per_o  = per_q;
  assign ovr_o  = ovr_q;
  assign rxi_o  = full_q & rie_i;
  assign eri_o  = (per_q | ovr_q) & rie_i;
endmodule

// File: rtl/scard_rx_chk.sv
module scard_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rie_i,
  input logic       rd_i,
  input logic       err_clr_i,
  input logic       frame_done,
  input logic       frame_good,
  input logic       line_oe_o,
  input logic [7:0] data_o,
  input logic       full_o,
  input logic       per_o,
  input logic       ovr_o,
  input logic       rxi_o,
  input logic       eri_o
);
  p_bad_no_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && !frame_good && !err_clr_i |=> per_o && $stable(data_o));

  p_bad_no_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && !frame_good && !rd_i |=> full_o == $past(full_o));

  p_good_sets_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_good |=> full_o);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !frame_done |=> !full_o);

  p_overrun_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_good && full_o && !rd_i && !err_clr_i |=> ovr_o && $stable(data_o));

  p_no_drive_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |-> !line_oe_o);

  p_rxi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxi_o |-> full_o && rie_i);

  p_eri_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eri_o |-> rie_i && (per_o || ovr_o));
endmodule

bind scard_rx scard_rx_chk u_chk (.*);

// File: tb/scard_rx_tb.sv
module scard_rx_tb;
  localparam int BIT = 16;
  localparam int ERR = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       card = 1'b1;
  logic       line_i;
  logic       line_oe_o;
  logic       rie_i = 1'b1;
  logic       rd_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic [7:0] data_o;
  logic       full_o, per_o, ovr_o, rxi_o, eri_o;

  int checks = 0, failures = 0;
  int cyc = 0, start_cyc = 0, first_oe = -1, oe_cnt = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;
  assign line_i = card & ~line_oe_o;

  scard_rx #(.BIT_CYC(BIT), .ERR_CYC(ERR), .SYNC_STAGES(2)) u_dut (
    .clk_i, .rst_ni, .line_i, .line_oe_o, .rie_i, .rd_i, .err_clr_i,
    .data_o, .full_o, .per_o, .ovr_o, .rxi_o, .eri_o
  );

  always @(negedge clk_i) begin
    cyc++;
    if (line_oe_o) begin
      if (first_oe < 0) first_oe = cyc - start_cyc;
      oe_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit bad);
    logic [9:0] bits;
    bits = {(^b) ^ bad, b, 1'b0};
    @(negedge clk_i);
    start_cyc = cyc; first_oe = -1; oe_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      card = bits[i];
      repeat (BIT) @(negedge clk_i);
    end
    card = 1'b1;
    repeat (3 * BIT) @(negedge clk_i);
  endtask

  task automatic pulse_rd();
    @(negedge clk_i) rd_i = 1'b1;
    @(negedge clk_i) rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    @(negedge clk_i) err_clr_i = 1'b1;
    @(negedge clk_i) err_clr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(data_o == 8'h00 && !full_o && !per_o && !ovr_o, "R1 flags",
        {ovr_o, per_o, full_o, data_o}, 0);
    chk(!line_oe_o, "R1 oe", line_oe_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R2 short glitch ignored
    start_cyc = cyc; oe_cnt = 0;
    card = 1'b0;
    repeat (3) @(negedge clk_i);
    card = 1'b1;
    repeat (12 * BIT) @(negedge clk_i);
    chk(!full_o && !per_o && !ovr_o, "R2 glitch flags", {ovr_o, per_o, full_o}, 0);
    chk(oe_cnt == 0, "R2 glitch oe", oe_cnt, 0);

    // R3 R4 R6 R7 R10 sweep of all bytes with good parity
    for (int v = 0; v < 256; v++) begin
      send(8'(v), 1'b0);
      chk(data_o == 8'(v), "R3 data", data_o, v);
      chk(full_o && !per_o, "R4 full", {per_o, full_o}, 1);
      chk(oe_cnt == 0, "R6 no drive on good", oe_cnt, 0);
      chk(rxi_o == 1'b1, "R10 rxi", rxi_o, 1);
      pulse_rd();
      chk(!full_o, "R7 read clears", full_o, 0);
    end
    last = 8'hFF;

    // R5 R6 R8 R10 corrupted parity
    for (int k = 0; k < 64; k++) begin
      logic [7:0] b;
      b = 8'(k * 4 + 1);
      send(b, 1'b1);
      chk(per_o, "R5 per set", per_o, 1);
      chk(!full_o, "R5 full untouched", full_o, 0);
      chk(data_o == last, "R5 data kept", data_o, last);
      chk(oe_cnt == ERR, "R6 pulse width", oe_cnt, ERR);
      chk(first_oe >= 10 * BIT - 1 && first_oe <= 10 * BIT + 6, "R6 pulse start",
          first_oe, 10 * BIT + 3);
      chk(eri_o, "R10 eri", eri_o, 1);
      pulse_clr();
      chk(!per_o && !eri_o, "R8 clear", {eri_o, per_o}, 0);
    end

    // R8 retransmission received normally
    send(8'h5A, 1'b0);
    chk(data_o == 8'h5A && full_o, "R8 retransmit", data_o, 8'h5A);
    pulse_rd();

    // R9 overrun, R10 with interrupts disabled
    send(8'hA5, 1'b0);
    send(8'h3C, 1'b0);
    chk(ovr_o, "R9 overrun flag", ovr_o, 1);
    chk(data_o == 8'hA5, "R9 data kept", data_o, 8'hA5);
    chk(eri_o, "R10 eri on overrun", eri_o, 1);
    @(negedge clk_i) rie_i = 1'b0;
    @(negedge clk_i);
    chk(!rxi_o && !eri_o, "R10 masked", {eri_o, rxi_o}, 0);
    pulse_clr();
    chk(!ovr_o, "R8 overrun clear", ovr_o, 0);

    finish_run();
  end
endmodule